// File: doc/BRIEF.md
# BCD Decimal Adjust Flag Unit

This unit carries out the decimal adjust step of an 8-bit accumulator CPU. It runs after a binary add or subtract has been applied to two packed BCD operands. It takes the raw accumulator and the flag byte that the arithmetic left behind. From these it forms a corrected two-digit BCD accumulator and a new flag byte.

The stored negative flag chooses the direction of the correction. When it is clear, the corrections are added. When it is set, they are subtracted. Each correction is chosen only from the original accumulator and the incoming half-carry and carry bits.

A one-cycle start strobe launches an operation. One clock later the corrected accumulator and flags appear on registered outputs, together with a one-cycle done pulse. The outputs then hold their values until the next start.

Top module: `bcd_adj_unit`

## Requirements
- R1: A low correction of 0x06 is selected when input flag bit 4 (half-carry) is 1 or the accumulator's low nibble exceeds 9; with input flag bit 1 (negative) at 0 it is added to the accumulator.
- R2: A high correction of 0x60 is selected when input flag bit 0 (carry) is 1 or the original accumulator exceeds 0x99; with the negative bit at 0 it is added. Both corrections are chosen from the original accumulator only, and both may apply together.
- R3: With input flag bit 1 at 1, the selected corrections are subtracted instead of added. All correction arithmetic wraps modulo 256.
- R4: Output flag bit 0 (carry) is the input carry ORed with (original accumulator > 0x99), so it is never cleared. Output flag bit 1 equals input flag bit 1.
- R5: Output flag bit 4 equals bit 4 of (original accumulator XOR corrected result).
- R6: Output flag bit 7 is bit 7 of the result. Output flag bit 6 is 1 when the result is 0x00. Output flag bit 2 is 1 when the result has an even number of one bits.
- R7: Output flag bits 3 and 5 are always 0. Input flag bits 2, 3, 5, 6 and 7 do not affect any output.
- R8: `done_o` is high for exactly the one cycle after a cycle with `start_i` high. The result and flags are registered at that point and hold while `start_i` stays low, whatever the data inputs do.
- R9: A synchronous active-high reset clears `acc_o`, `flags_o` and `done_o`, and it takes priority over a start in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch one adjust operation |
| acc_i | input | 8 | Accumulator after the binary add or subtract |
| flags_i | input | 8 | Flag byte after the binary add or subtract |
| acc_o | output | 8 | Decimal-corrected accumulator |
| flags_o | output | 8 | Updated flag byte |
| done_o | output | 1 | One-cycle pulse when the outputs are updated |

## Verification
The bench sweeps all 256 accumulator values under all eight combinations of input carry, negative and half-carry. It also fills the unused flag bits with a changing pattern. Results are compared field by field with an arithmetic model.

The sweep targets the edges of the correction rules:
- A low nibble of exactly 9 versus 10, where the wrong comparison would misplace the 0x06 step.
- An accumulator of 0x99 versus 0x9A, where an off-by-one would drop the high step and lose the carry.
- Cases with carry already set and no overflow, where a design that recomputes carry would clear it.
- The subtract path with wrap below zero, where a design that ignored the negative bit or saturated would produce wrong digits.
- A half-carry taken from a nibble adder instead of the XOR, which shows up on subtract corrections.

Between operations the bench changes the data inputs with start low, which exposes any output that is not held. A start during reset checks the reset priority.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;
   localparam int FLAG_W = 8;
   localparam int FLG_C  = 0;
   localparam int FLG_N  = 1;
   localparam int FLG_P  = 2;
   localparam int FLG_X  = 3;
   localparam int FLG_H  = 4;
   localparam int FLG_Y  = 5;
   localparam int FLG_Z  = 6;
   localparam int FLG_S  = 7;

   typedef struct packed {
      logic fix_lo;
      logic fix_hi;
      logic over_lim;
   } adj_sel_t;
endpackage

// File: rtl/bcd_adj_detect.sv
module bcd_adj_detect #(
   parameter int WORD_W  = 8,
   parameter int DIGIT_W = 4
) (
   input  logic [WORD_W-1:0]    acc_i,
   input  logic                 car_i,
   input  logic                 half_i,
   output bcd_adj_pkg::adj_sel_t sel_o
);
   localparam int NDIG = WORD_W / DIGIT_W;
   localparam logic [WORD_W-1:0]  BCD_MAX  = {NDIG{4'h9}};
   localparam logic [DIGIT_W-1:0] DIGIT_MX = DIGIT_W'(9);

   logic over_lim;
   logic lo_big;

   assign over_lim = acc_i > BCD_MAX;
   assign lo_big   = acc_i[DIGIT_W-1:0] > DIGIT_MX;

   always_comb begin
      sel_o.fix_lo   = half_i | lo_big;
      sel_o.fix_hi   = car_i | over_lim;
      sel_o.over_lim = over_lim;
   end
endmodule

// File: rtl/bcd_adj_apply.sv
module bcd_adj_apply #(
   parameter int WORD_W  = 8,
   parameter int DIGIT_W = 4
) (
   input  logic [WORD_W-1:0] acc_i,
   input  logic              fix_lo_i,
   input  logic              fix_hi_i,
   input  logic              sub_i,
   output logic [WORD_W-1:0] res_o
);
   localparam logic [WORD_W-1:0] LO_STEP = WORD_W'(6);
   localparam logic [WORD_W-1:0] HI_STEP = LO_STEP << DIGIT_W;

   logic [WORD_W-1:0] corr;

   always_comb begin
      corr = '0;
      if (fix_lo_i) corr = corr | LO_STEP;
      if (fix_hi_i) corr = corr | HI_STEP;
      if (sub_i) res_o = acc_i - corr;
      else       res_o = acc_i + corr;
   end
endmodule

// File: rtl/bcd_adj_flags.sv
module bcd_adj_flags #(
   parameter int WORD_W       = 8,
   parameter int PARITY_CHAIN = 0
) (
   input  logic [WORD_W-1:0]              acc_i,
   input  logic [WORD_W-1:0]              res_i,
   input  logic [bcd_adj_pkg::FLAG_W-1:0] flags_i,
   input  logic                           over_lim_i,
   output logic [bcd_adj_pkg::FLAG_W-1:0] flags_o
);
   import bcd_adj_pkg::*;

   logic odd;
   logic [WORD_W-1:0] diff;

   assign diff = acc_i ^ res_i;

   generate
      if (PARITY_CHAIN != 0) begin : g_chain
         logic [WORD_W-1:0] run;
         assign run[0] = res_i[0];
         for (genvar i = 1; i < WORD_W; i++) begin : g_stage
            assign run[i] = run[i-1] ^ res_i[i];
         end
         assign odd = run[WORD_W-1];
      end else begin : g_reduce
         assign odd = ^res_i;
      end
   endgenerate

   always_comb begin
      flags_o        = '0;
      flags_o[FLG_C] = flags_i[FLG_C] | over_lim_i;
      flags_o[FLG_N] = flags_i[FLG_N];
      flags_o[FLG_H] = diff[4];
      flags_o[FLG_P] = ~odd;
      flags_o[FLG_Z] = (res_i == '0);
      flags_o[FLG_S] = res_i[WORD_W-1];
   end
endmodule

// File: rtl/bcd_adj_unit.sv
module bcd_adj_unit #(
   parameter int WORD_W       = 8,
   parameter int PARITY_CHAIN = 0
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        start_i,
   input  logic [7:0]  acc_i,
   input  logic [7:0]  flags_i,
   output logic [7:0]  acc_o,
   output logic [7:0]  flags_o,
   output logic        done_o
);
   import bcd_adj_pkg::*;

   localparam int DIGIT_W = WORD_W / 2;

   generate
      if (WORD_W != 8) begin : g_bad_width
         $error("bcd_adj_unit supports an 8-bit accumulator only");
      end
   endgenerate

   adj_sel_t            sel;
   logic [WORD_W-1:0]   res;
   logic [FLAG_W-1:0]   nflags;

   bcd_adj_detect #(.WORD_W(WORD_W), .DIGIT_W(DIGIT_W)) u_detect (
      .acc_i  (acc_i),
      .car_i  (flags_i[FLG_C]),
      .half_i (flags_i[FLG_H]),
      .sel_o  (sel)
   );

   bcd_adj_apply #(.WORD_W(WORD_W), .DIGIT_W(DIGIT_W)) u_apply (
      .acc_i    (acc_i),
      .fix_lo_i (sel.fix_lo),
      .fix_hi_i (sel.fix_hi),
      .sub_i    (flags_i[FLG_N]),
      .res_o    (res)
   );

   bcd_adj_flags #(.WORD_W(WORD_W), .PARITY_CHAIN(PARITY_CHAIN)) u_flags (
      .acc_i      (acc_i),
      .res_i      (res),
      .flags_i    (flags_i),
      .over_lim_i (sel.over_lim),
      .flags_o    (nflags)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_o   <= '0;
         flags_o <= '0;
         done_o  <= 1'b0;
      end else begin
         done_o <= start_i;
         if (start_i) begin
            acc_o   <= res;
            flags_o <= nflags;
         end
      end
   end

   // R8
   done_after_start_chk: assert property (@(posedge clk) disable iff (rst)
      done_o |-> $past(start_i));
   // R8
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (!start_i && !$past(rst)) |=> ($stable(acc_o) && $stable(flags_o)));
   // R4
   carry_kept_chk: assert property (@(posedge clk) disable iff (rst)
      (start_i && flags_i[FLG_C]) |=> flags_o[FLG_C]);
   // R4
   neg_kept_chk: assert property (@(posedge clk) disable iff (rst)
      start_i |=> (flags_o[FLG_N] == $past(flags_i[FLG_N])));
   // R6
   zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
      done_o |-> (flags_o[FLG_Z] == (acc_o == 8'h00)));
   // R7
   spare_bits_chk: assert property (@(posedge clk) disable iff (rst)
      done_o |-> (!flags_o[FLG_X] && !flags_o[FLG_Y]));
endmodule

// File: tb/bcd_adj_unit_bench.sv
module bcd_adj_unit_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start_i = 1'b0;
   logic [7:0] acc_i = 8'h00;
   logic [7:0] flags_i = 8'h00;
   logic [7:0] acc_o;
   logic [7:0] flags_o;
   logic       done_o;

   int checks = 0;
   int errors = 0;
   bit ended = 0;

   always #2 clk = ~clk;

   bcd_adj_unit u_bcd_adj_unit (
      .clk(clk), .rst(rst), .start_i(start_i), .acc_i(acc_i),
      .flags_i(flags_i), .acc_o(acc_o), .flags_o(flags_o), .done_o(done_o)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(4 * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [7:0] a, fi, corr, r, ef, held_a, held_f;
      bit c, n, h, lo, hi;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(acc_o == 8'h00, "R9 reset acc", acc_o, 8'h00);
      chk(flags_o == 8'h00, "R9 reset flags", flags_o, 8'h00);
      chk(done_o == 1'b0, "R9 reset done", {7'd0, done_o}, 8'h00);
      rst = 1'b0;
      @(negedge clk);
      chk(done_o == 1'b0, "R8 idle done", {7'd0, done_o}, 8'h00);

      for (int k = 0; k < 8; k++) begin
         for (int v = 0; v < 256; v++) begin
            a = 8'(v);
            c = k[0];
            n = k[1];
            h = k[2];
            fi = (8'(v * 7 + k * 13) & 8'hEC) | {3'b0, h, 2'b0, n, c};
            lo = h || (a[3:0] > 4'd9);
            hi = c || (a > 8'h99);
            corr = (lo ? 8'h06 : 8'h00) | (hi ? 8'h60 : 8'h00);
            r = n ? a - corr : a + corr;
            ef = 8'h00;
            ef[0] = c | (a > 8'h99);
            ef[1] = n;
            ef[4] = a[4] ^ r[4];
            ef[2] = ~(^r);
            ef[6] = (r == 8'h00);
            ef[7] = r[7];

            acc_i = a;
            flags_i = fi;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            chk(done_o == 1'b1, "R8 done pulse", {7'd0, done_o}, 8'h01);
            if (n)
               chk(acc_o == r, "R3 subtract result", acc_o, r);
            else if (hi)
               chk(acc_o == r, "R2 high add result", acc_o, r);
            else
               chk(acc_o == r, "R1 low add result", acc_o, r);
            chk(flags_o[1:0] == ef[1:0], "R4 carry/neg", flags_o, ef);
            chk(flags_o[4] == ef[4], "R5 half flag", flags_o, ef);
            chk((flags_o & 8'hC4) == (ef & 8'hC4), "R6 sign/zero/parity", flags_o, ef);
            chk((flags_o & 8'h28) == 8'h00, "R7 spare bits", flags_o, ef);

            held_a = acc_o;
            held_f = flags_o;
            acc_i = ~a;
            flags_i = ~fi;
            @(negedge clk);
            chk(done_o == 1'b0, "R8 done drops", {7'd0, done_o}, 8'h00);
            chk(acc_o == held_a && flags_o == held_f, "R8 hold", acc_o, held_a);
         end
      end

      acc_i = 8'h9A;
      flags_i = 8'h00;
      start_i = 1'b1;
      rst = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(acc_o == 8'h00 && flags_o == 8'h00, "R9 reset beats start", acc_o, 8'h00);
      chk(done_o == 1'b0, "R9 reset beats start done", {7'd0, done_o}, 8'h00);
      rst = 1'b0;
      @(negedge clk);
      finish_run();
   end
endmodule